// File: doc/BRIEF.md
# Eight-Function Byte ALU with Rotator

This block is an 8-bit arithmetic and logic unit. It takes two byte operands and a 3-bit function select, and returns a byte result with three flags: zero, carry and overflow. There are eight functions: bitwise AND, bitwise OR, complement of A, rotate left, rotate right, add, subtract and a 4x4 multiply that returns a full 8-bit product. The rotate distance comes from the low three bits of operand B. Bits that leave one end of the word come back in at the other end.

Each function has its own datapath, and an 8-way case statement picks the result. Rotation uses a logarithmic network of three multiplexer stages, where stage k moves the word by 2^k places. Add and subtract share one ripple-carry adder. For subtract, the adder inverts B and sets the carry-in. The multiplier is a separate combinational instance that uses only the low nibble of each operand. The result and the flags are registered, so they appear one clock edge after the inputs are sampled. A synchronous active-high reset clears all outputs.

Top module: `alu8_core`

## Requirements
- R1: Outputs are registered. Inputs sampled at a rising clock edge appear on the outputs just after that edge. When `rst` is high at an edge, the result and all three flags become 0.
- R2: Function code 0 returns A AND B, code 1 returns A OR B, and code 2 returns the bitwise complement of A. Operand B has no effect for code 2.
- R3: Function code 3 rotates A left by B[2:0] places. The bit leaving bit 7 enters at bit 0, and B[7:3] has no effect.
- R4: Function code 4 rotates A right by B[2:0] places. The bit leaving bit 0 enters at bit 7, and B[7:3] has no effect.
- R5: Function code 5 returns the low 8 bits of A+B. The carry flag holds bit 8 of the sum.
- R6: Function code 6 returns the low 8 bits of A-B. The carry flag is 1 exactly when A >= B as unsigned numbers (no borrow).
- R7: For codes 5 and 6, the overflow flag is 1 exactly when the two's-complement result does not fit in 8 bits. That is the case when the sign of A equals the sign of the effective second operand (B for add, NOT B for subtract) and the result sign differs.
- R8: Function code 7 returns the unsigned 8-bit product A[3:0]*B[3:0]. Bits 7:4 of both operands have no effect.
- R9: The zero flag is 1 exactly when all 8 result bits are 0, for every function code.
- R10: For codes 0 to 4 and code 7, the carry and overflow flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Function select, encoding as in R2 to R8 |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| result_o | output | 8 | Registered result |
| zero_o | output | 1 | Registered zero flag |
| carry_o | output | 1 | Registered carry / no-borrow flag |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The bench uses rotate distances of 0 and 7, and sets upper B bits that must be ignored. A rotator with a miswired stage, or one that shifts in zeros, gives a wrong byte on these. Signed overflow is checked on both boundaries (0x7F+1 and 0x80-1) and on the wrap 0x80+0x80. An inverted overflow test or a missing subtract inversion of B shows up there. Subtract carry is checked with equal operands and with A < B, which catches a design that reports borrow instead of no-borrow. Multiplies with nonzero upper nibbles catch a product that leaks operand bits 7:4, and a sweep over all eight codes catches flags left active outside add and subtract.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    FN_AND = 3'd0,
    FN_OR  = 3'd1,
    FN_NOT = 3'd2,
    FN_ROL = 3'd3,
    FN_ROR = 3'd4,
    FN_ADD = 3'd5,
    FN_SUB = 3'd6,
    FN_MUL = 3'd7
  } alu_fn_e;
endpackage

// File: rtl/alu8_rotator.sv
module alu8_rotator #(
  parameter int  W       = 8,
  parameter bit  LEFT    = 1'b1,
  localparam int SW      = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [0:SW];
  assign stage[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [W-1:0] moved;
    if (LEFT) begin : g_left
      assign moved = {stage[k][W-1-D:0], stage[k][W-1:W-D]};
    end else begin : g_right
      assign moved = {stage[k][D-1:0], stage[k][W-1:D]};
    end
    assign stage[k+1] = amt[k] ? moved : stage[k];
  end

  assign dout = stage[SW];
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] bx;
  logic [W:0]   cy;

  assign bx    = b ^ {W{sub}};
  assign cy[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = a[i] ^ bx[i] ^ cy[i];
    assign cy[i+1] = (a[i] & bx[i]) | (cy[i] & (a[i] ^ bx[i]));
  end

  assign cout = cy[W];
  assign ovf  = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
  parameter int  MW = 4,
  localparam int PW = 2 * MW
) (
  input  logic [MW-1:0] a,
  input  logic [MW-1:0] b,
  output logic [PW-1:0] prod
);
  always_comb begin
    prod = '0;
    for (int i = 0; i < MW; i++) begin
      if (b[i]) prod = prod + (PW'(a) << i);
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int  W  = 8,
  parameter int  MW = 4,
  localparam int SW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         carry_o,
  output logic         ovf_o
);
  alu_fn_e      fn;
  logic [W-1:0] rol_w, ror_w, sum_w, mul_w, res_d;
  logic         cout_w, ovf_w, carry_d, ovf_d;

  assign fn = alu_fn_e'(op_i);

  alu8_rotator #(.W(W), .LEFT(1'b1)) u_rol (
    .din(a_i), .amt(b_i[SW-1:0]), .dout(rol_w)
  );

  alu8_rotator #(.W(W), .LEFT(1'b0)) u_ror (
    .din(a_i), .amt(b_i[SW-1:0]), .dout(ror_w)
  );

  alu8_addsub #(.W(W)) u_addsub (
    .a(a_i), .b(b_i), .sub(fn == FN_SUB),
    .sum(sum_w), .cout(cout_w), .ovf(ovf_w)
  );

  logic [2*MW-1:0] prod_w;
  alu8_mul #(.MW(MW)) u_mul (
    .a(a_i[MW-1:0]), .b(b_i[MW-1:0]), .prod(prod_w)
  );
  assign mul_w = W'(prod_w);

  always_comb begin
    carry_d = 1'b0;
    ovf_d   = 1'b0;
    unique case (fn)
      FN_AND: res_d = a_i & b_i;
      FN_OR:  res_d = a_i | b_i;
      FN_NOT: res_d = ~a_i;
      FN_ROL: res_d = rol_w;
      FN_ROR: res_d = ror_w;
      FN_ADD, FN_SUB: begin
        res_d   = sum_w;
        carry_d = cout_w;
        ovf_d   = ovf_w;
      end
      FN_MUL: res_d = mul_w;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      zero_o   <= 1'b0;
      carry_o  <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_d;
      zero_o   <= (res_d == '0);
      carry_o  <= carry_d;
      ovf_o    <= ovf_d;
    end
  end

  // R1: reset clears all outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (result_o == '0 && !zero_o && !carry_o && !ovf_o));

  // R2: AND path
  p_and_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == FN_AND) |-> result_o == ($past(a_i) & $past(b_i)));

  // R5: add result with carry
  p_add_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == FN_ADD) |->
      {carry_o, result_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)}));

  // R6: subtract carry means no borrow
  p_sub_nb_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == FN_SUB) |-> carry_o == ($past(a_i) >= $past(b_i)));

  // R8: product of low nibbles
  p_mul_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == FN_MUL) |->
      result_o == W'($past(a_i[MW-1:0]) * $past(b_i[MW-1:0])));

  // R9: zero flag tracks result
  p_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> zero_o == (result_o == '0));

  // R10: flags quiet outside add/subtract
  p_flags_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) != FN_ADD && $past(op_i) != FN_SUB) |-> (!carry_o && !ovf_o));
endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op  = '0;
  logic [7:0] a   = '0;
  logic [7:0] b   = '0;
  logic [7:0] res;
  logic       zf, cf, vf;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  alu8_core dut (
    .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b),
    .result_o(res), .zero_o(zf), .carry_o(cf), .ovf_o(vf)
  );

  // {op, a, b, result, zero, carry, ovf}
  localparam int NV = 17;
  localparam logic [29:0] VEC [NV] = '{
    {3'd0, 8'h55, 8'hAA, 8'h00, 1'b1, 1'b0, 1'b0},  // R2 AND
    {3'd1, 8'h55, 8'hAA, 8'hFF, 1'b0, 1'b0, 1'b0},  // R2 OR
    {3'd2, 8'h55, 8'hAA, 8'hAA, 1'b0, 1'b0, 1'b0},  // R2 NOT
    {3'd3, 8'h2B, 8'h02, 8'hAC, 1'b0, 1'b0, 1'b0},  // R3
    {3'd4, 8'h2B, 8'h02, 8'hCA, 1'b0, 1'b0, 1'b0},  // R4
    {3'd3, 8'h81, 8'hFF, 8'hC0, 1'b0, 1'b0, 1'b0},  // R3 by 7, high B ignored
    {3'd4, 8'h81, 8'hF8, 8'h81, 1'b0, 1'b0, 1'b0},  // R4 by 0
    {3'd5, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b0, 1'b1},  // R5 R7
    {3'd5, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1, 1'b0},  // R5 carry
    {3'd5, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1, 1'b1},  // R7 wrap
    {3'd6, 8'h05, 8'h05, 8'h00, 1'b1, 1'b1, 1'b0},  // R6 equal
    {3'd6, 8'h03, 8'h05, 8'hFE, 1'b0, 1'b0, 1'b0},  // R6 borrow
    {3'd6, 8'h80, 8'h01, 8'h7F, 1'b0, 1'b1, 1'b1},  // R7 sub
    {3'd7, 8'hF3, 8'h22, 8'h06, 1'b0, 1'b0, 1'b0},  // R8
    {3'd7, 8'h0F, 8'h0F, 8'hE1, 1'b0, 1'b0, 1'b0},  // R8 max
    {3'd7, 8'hF0, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0},  // R8 R9
    {3'd2, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0}   // R9 NOT
  };

  function automatic logic [10:0] model(input logic [2:0] f, input logic [7:0] x, input logic [7:0] y);
    logic [7:0] r;
    logic [8:0] s;
    logic c, v;
    logic [15:0] dbl;
    c = 1'b0; v = 1'b0; r = 8'h00;
    dbl = {x, x};
    case (f)
      3'd0: r = x & y;
      3'd1: r = x | y;
      3'd2: r = ~x;
      3'd3: begin dbl = dbl << y[2:0]; r = dbl[15:8]; end
      3'd4: begin dbl = dbl >> y[2:0]; r = dbl[7:0]; end
      3'd5: begin s = {1'b0, x} + {1'b0, y}; r = s[7:0]; c = s[8];
                  v = (x[7] == y[7]) && (r[7] != x[7]); end
      3'd6: begin r = x - y; c = (x >= y);
                  v = (x[7] != y[7]) && (r[7] != x[7]); end
      default: r = 8'(x[3:0] * y[3:0]);
    endcase
    return {r, (r == 8'h00), c, v};
  endfunction

  task automatic apply(input logic [2:0] f, input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    op = f; a = x; b = y;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [10:0] exp);
    checks++;
    if ({res, zf, cf, vf} !== exp) begin
      errors++;
      $display("FAIL %s: op=%0d a=%h b=%h got res=%h z=%b c=%b v=%b expected res=%h z=%b c=%b v=%b",
               tag, op, a, b, res, zf, cf, vf, exp[10:3], exp[2], exp[1], exp[0]);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state with inputs that would give nonzero outputs
    op = 3'd5; a = 8'hFF; b = 8'h01;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1 reset state", 11'b0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][29:27], VEC[i][26:19], VEC[i][18:11]);
      expect_out($sformatf("vector %0d (R2-R10 table)", i), VEC[i][10:0]);
    end

    // R2: B ignored for NOT
    apply(3'd2, 8'h3C, 8'hFF);
    expect_out("R2 NOT ignores B", {8'hC3, 3'b000});
    // R3 / R4: every distance, upper B bits set
    for (int k = 0; k < 8; k++) begin
      apply(3'd3, 8'h96, 8'(k) | 8'hA8);
      expect_out("R3 rotate left sweep", model(3'd3, 8'h96, 8'(k)));
      apply(3'd4, 8'h96, 8'(k) | 8'h50);
      expect_out("R4 rotate right sweep", model(3'd4, 8'h96, 8'(k)));
    end
    // R10 / R9: every code, several patterns
    for (int f = 0; f < 8; f++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] x, y;
        x = 8'(8'h5B * (p + 1) + f);
        y = 8'(8'hC7 ^ (p * 8'h31));
        apply(3'(f), x, y);
        expect_out("R10 R9 R7 code sweep", model(3'(f), x, y));
      end
    end
    // R8: upper nibbles ignored
    apply(3'd7, 8'hA7, 8'h5B);
    expect_out("R8 high nibbles ignored", {8'd77, 3'b000});
    // R1: reset mid-run clears outputs
    apply(3'd5, 8'hFF, 8'hFF);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    expect_out("R1 reset mid-run", 11'b0);
    @(negedge clk);
    rst = 1'b0;
    apply(3'd6, 8'h10, 8'h20);
    expect_out("R1 R6 after reset", {8'hF0, 3'b000});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule